// File: doc/BRIEF.md
# External bus wait-state sequencer

This block runs one external memory cycle at a time on a narrow microcontroller-style bus, where the low address byte and the data byte share the same lines. A request carries an address, a direction and, for writes, a data byte. The block accepts it while idle and drives an address-latch strobe for one clock. During that clock the full address is on the address lines and the low byte is on the shared lines. A read or write strobe follows. It stays asserted for one clock plus a number of wait states. When the strobe ends, the block pulses a done output, and for a read it also presents the byte it captured.

The wait-state count applies only to one memory region, chosen by the top address bits. It is set by a float-enable bit and a two-bit wait code. With the float-enable bit at 1 (compatible timing), the code gives 0 to 3 wait states. With it at 0, extended data float is active. The code then maps to only 1 or 3 wait states, and every cycle gets one extra idle clock after the strobe is released. That clock gives a slow device time to let go of the shared lines before the next address phase. A hold input from the device can stretch the strobe further, but only while a wait-enable control is set. A separate enable turns on a free-running square wave at half the clock rate, for devices that want a wait clock.

Top module: `xbus_seq`

## Requirements
- R1: While and right after reset, the block is idle: `req_ready` is 1, `bus_ale`, `bus_rd`, `bus_wr`, `bus_oe`, `rsp_done` and `wclk` are 0.
- R2: Each accepted request produces exactly one `bus_ale` clock. During it, `bus_addr` equals the request address, `bus_ad_out` equals the address low byte, `bus_oe` is 1 and no strobe is active. The strobe starts in the next clock.
- R3: In the wait region (address top two bits equal to 2'b01) with `cfg_edf`=1, `cfg_wsb` values 2'b11, 2'b10, 2'b01 and 2'b00 give strobes of 1, 2, 3 and 4 clocks (0 to 3 wait states).
- R4: In the wait region with `cfg_edf`=0, `cfg_wsb` 2'b11 or 2'b10 gives a 2-clock strobe and 2'b01 or 2'b00 gives a 4-clock strobe.
- R5: Outside the wait region, the strobe lasts exactly 1 clock whatever the configuration.
- R6: With `cfg_edf`=0, one idle clock with `req_ready`=0 follows the strobe. Back to back, the next `bus_ale` comes 2 clocks after the strobe ends. With `cfg_edf`=1 it comes 1 clock after, and `req_ready` is already 1 in the clock after the strobe.
- R7: When `wait_en`=1, each clock in which `ext_wait`=1 at the end of the programmed strobe extends the strobe by one clock. When `wait_en`=0, `ext_wait` has no effect on strobe length.
- R8: A read asserts `bus_rd` with `bus_oe`=0. The value on `bus_ad_in` in the last strobe clock appears on `rsp_rdata` together with `rsp_done`.
- R9: A write asserts `bus_wr` with `bus_oe`=1 and `bus_ad_out` equal to the write byte for every strobe clock.
- R10: `rsp_done` is a single-clock pulse in the clock right after the last strobe clock. `req_ready` is 0 from the address clock until the cycle ends.
- R11: While `wclk_en`=1, `wclk` changes value every clock. While `wclk_en`=0, `wclk` is 0.
- R12: `cfg_edf` and `cfg_wsb` are sampled when a request is accepted. Changing them during the cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write byte |
| cfg_edf | input | 1 | 1 = compatible timing, 0 = extended data float |
| cfg_wsb | input | 2 | Wait code for the wait region |
| wait_en | input | 1 | Honour `ext_wait` |
| wclk_en | input | 1 | Enable the wait-clock square wave |
| ext_wait | input | 1 | Device hold request, active high |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_oe | output | 1 | 1 = block drives the shared lines |
| bus_addr | output | AW | Address lines |
| bus_ad_out | output | DW | Shared address/data lines, outgoing |
| bus_ad_in | input | DW | Shared address/data lines, incoming |
| rsp_done | output | 1 | Cycle complete pulse |
| rsp_rdata | output | DW | Captured read byte |
| wclk | output | 1 | Wait clock, half the clock rate |

## Verification
All eight float/code combinations are run in the wait region. This separates the compatible mapping from the remapped one, which never yields 0 or 2 wait states. Each combination is run with no hold, with a short hold (only the 0- and 1-wait codes stretch) and with a long hold (every code stretches), and once with the hold present but not enabled. Reads and writes outside the region, pairs of requests issued back to back, and a configuration change in the middle of a cycle show the float idle clock, the zero-wait default and the sampling point. A check at the moment of the done pulse tells the float idle clock apart from a longer strobe.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_WS_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_STRB  = 2'd2,
        ST_FLOAT = 2'd3
    } xbus_state_e;

    typedef struct packed {
        logic       edf;
        logic [1:0] wsb;
    } xbus_cfg_t;

    typedef struct packed {
        logic [XB_WS_W-1:0] waits;
        logic               float_on;
    } xbus_timing_t;

    // Wait states for one access; outside the wait region there are none.
    function automatic logic [XB_WS_W-1:0] ws_for(input xbus_cfg_t c, input logic in_region);
        logic [XB_WS_W-1:0] w;
        if (!in_region)
            w = '0;
        else if (c.edf)
            w = XB_WS_W'(2'd3 - c.wsb);
        else
            w = c.wsb[1] ? XB_WS_W'(1) : XB_WS_W'(3);
        return w;
    endfunction

endpackage

// File: rtl/xbus_ws_decode.sv
module xbus_ws_decode
    import xbus_pkg::*;
(
    input  xbus_cfg_t    cfg,
    input  logic         in_region,
    output xbus_timing_t timing
);

    always_comb begin
        timing.waits    = ws_for(cfg, in_region);
        timing.float_on = ~cfg.edf;
    end

    // R4
    always_comb begin
        remap_chk: assert (!(in_region && !cfg.edf) || timing.waits == 2'd1 || timing.waits == 2'd3)
            else $error("extended-float wait count outside {1,3}");
    end

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  xbus_timing_t  timing,
    input  logic          wait_en,
    input  logic          ext_wait,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_oe,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_ad_out,
    input  logic [DW-1:0] bus_ad_in,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);

    xbus_state_e        state;
    logic [XB_WS_W-1:0] cnt;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;
    logic               write_q;
    logic               float_q;
    logic               done_q;
    logic [DW-1:0]      rdata_q;
    logic               hold;
    logic               strobe;

    assign hold   = wait_en & ext_wait;
    assign strobe = (state == ST_STRB);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            float_q <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        cnt     <= timing.waits;
                        float_q <= timing.float_on;
                        state   <= ST_ADDR;
                    end
                end
                ST_ADDR: state <= ST_STRB;
                ST_STRB: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!hold) begin
                        done_q <= 1'b1;
                        if (!write_q)
                            rdata_q <= bus_ad_in;
                        state <= float_q ? ST_FLOAT : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        bus_ale    = (state == ST_ADDR);
        bus_rd     = strobe & ~write_q;
        bus_wr     = strobe & write_q;
        bus_oe     = bus_ale | bus_wr;
        bus_addr   = addr_q;
        if (bus_ale)
            bus_ad_out = addr_q[DW-1:0];
        else if (bus_wr)
            bus_ad_out = wdata_q;
        else
            bus_ad_out = '0;
        rsp_done   = done_q;
        rsp_rdata  = rdata_q;
    end

    // R2
    ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> !(bus_rd || bus_wr));
    // R2
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> (bus_rd || bus_wr));
    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_oe);
    // R7
    hold_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && cnt == '0 && hold) |=> (bus_rd || bus_wr));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R10
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(bus_rd || bus_wr));
    // R6
    float_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_rd || bus_wr) && float_q) |-> !req_ready);

endmodule

// File: rtl/xbus_wclk_gen.sv
module xbus_wclk_gen (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic wclk
);

    always_ff @(posedge clk) begin
        if (rst || !enable)
            wclk <= 1'b0;
        else
            wclk <= ~wclk;
    end

    // R11
    wclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(rst)) |-> (wclk != $past(wclk)));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int                AW        = 18,
    parameter int                DW        = 8,
    parameter int                REGION_W  = 2,
    parameter logic [REGION_W-1:0] WS_REGION = 2'b01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          cfg_edf,
    input  logic [1:0]    cfg_wsb,
    input  logic          wait_en,
    input  logic          wclk_en,
    input  logic          ext_wait,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_oe,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_ad_out,
    input  logic [DW-1:0] bus_ad_in,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          wclk
);

    xbus_cfg_t    cfg;
    xbus_timing_t timing;
    logic         in_region;

    assign cfg.edf   = cfg_edf;
    assign cfg.wsb   = cfg_wsb;
    assign in_region = (req_addr[AW-1 -: REGION_W] == WS_REGION);

    xbus_ws_decode u_decode (
        .cfg       (cfg),
        .in_region (in_region),
        .timing    (timing)
    );

    xbus_cycle_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .timing     (timing),
        .wait_en    (wait_en),
        .ext_wait   (ext_wait),
        .bus_ale    (bus_ale),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_oe     (bus_oe),
        .bus_addr   (bus_addr),
        .bus_ad_out (bus_ad_out),
        .bus_ad_in  (bus_ad_in),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata)
    );

    xbus_wclk_gen u_wclk (
        .clk    (clk),
        .rst    (rst),
        .enable (wclk_en),
        .wclk   (wclk)
    );

endmodule

// File: tb/test_xbus_seq.sv
module test_xbus_seq;

    localparam int AW = 18;
    localparam int DW = 8;

    typedef struct {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            len;
        int            gap;
        bit            rdy;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cfg_edf = 1'b1;
    logic [1:0]    cfg_wsb = 2'b11;
    logic          wait_en = 1'b0;
    logic          wclk_en = 1'b0;
    logic          ext_wait = 1'b0;
    logic          bus_ale, bus_rd, bus_wr, bus_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_ad_out;
    logic [DW-1:0] bus_ad_in;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          wclk;

    int    checks = 0;
    int    errors = 0;
    item_t q[$];
    item_t cur;
    int    strobe_len = 0;
    int    gap = 100;
    int    wait_len = 0;
    int    sc = 0;
    logic [DW-1:0] lat = '0;

    always #10 clk = ~clk;

    xbus_seq i_xbus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_edf(cfg_edf), .cfg_wsb(cfg_wsb), .wait_en(wait_en), .wclk_en(wclk_en),
        .ext_wait(ext_wait), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_ad_out(bus_ad_out),
        .bus_ad_in(bus_ad_in), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .wclk(wclk)
    );

    // memory model: returns latched low address byte xor 8'h5A
    assign bus_ad_in = bus_rd ? (lat ^ 8'h5A) : 8'h00;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_waits(input logic edf, input logic [1:0] wsb, input logic inreg);
        if (!inreg) return 0;
        if (edf) return 3 - int'(wsb);
        return wsb[1] ? 1 : 3;
    endfunction

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic edf, input logic [1:0] wsb, input logic wen,
                         input int wl, input int g, input string tag);
        item_t it;
        int n;
        n = exp_waits(edf, wsb, a[AW-1 -: 2] == 2'b01) + 1;
        it.wr  = wr;
        it.a   = a;
        it.d   = d;
        it.len = (wen && (wl + 1 > n)) ? wl + 1 : n;
        it.gap = g;
        it.rdy = edf;
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        cfg_edf   = edf;
        cfg_wsb   = wsb;
        wait_en   = wen;
        wait_len  = wl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // device hold responder: ext_wait high for the first wait_len strobe clocks
    always @(negedge clk) begin
        if (bus_ale) lat = bus_ad_out;
        if (bus_rd || bus_wr) sc = sc + 1; else sc = 0;
        ext_wait = (sc >= 1 && sc <= wait_len);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_ale) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected ALE", 1, 0);
                end else begin
                    cur = q[0];
                    chk(bus_addr == cur.a, "R2", "address", int'(bus_addr), int'(cur.a));
                    chk(bus_ad_out == cur.a[DW-1:0] && bus_oe, "R2", "low byte/oe",
                        int'(bus_ad_out), int'(cur.a[DW-1:0]));
                    if (cur.gap >= 0)
                        chk(gap == cur.gap, "R6", "strobe-to-ALE gap", gap, cur.gap);
                end
                chk(!req_ready, "R10", "ready in address clock", int'(req_ready), 0);
                strobe_len = 0;
            end
            if (bus_rd || bus_wr) begin
                strobe_len++;
                gap = 0;
                chk(!req_ready, "R10", "ready during strobe", int'(req_ready), 0);
                if (cur.wr)
                    chk(bus_wr && !bus_rd && bus_oe && bus_ad_out == cur.d, "R9",
                        "write strobe data", int'(bus_ad_out), int'(cur.d));
                else
                    chk(bus_rd && !bus_wr && !bus_oe, "R8", "read strobe/oe", int'(bus_oe), 0);
            end else if (!bus_ale) begin
                gap++;
            end
            if (rsp_done) begin
                if (q.size() != 0) begin
                    cur = q.pop_front();
                    chk(strobe_len == cur.len, cur.tag, "strobe length", strobe_len, cur.len);
                    chk(req_ready == cur.rdy, "R6", "ready with done", int'(req_ready), int'(cur.rdy));
                    if (!cur.wr)
                        chk(rsp_rdata == (cur.a[DW-1:0] ^ 8'h5A), "R8", "read data",
                            int'(rsp_rdata), int'(cur.a[DW-1:0] ^ 8'h5A));
                end else begin
                    chk(1'b0, "R10", "done without cycle", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !bus_ale && !bus_rd && !bus_wr && !bus_oe && !rsp_done && !wclk,
            "R1", "reset outputs", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_ale && !bus_oe && !wclk, "R1", "after reset", 0, 0);

        // R3 / R4 / R7: every float/code combination in the wait region
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 4; w++) begin
                logic [AW-1:0] a;
                a = {2'b01, 16'h1200} + AW'(e * 16 + w);
                issue(1'b0, a, 8'h00, e[0], w[1:0], 1'b0, 0, -1, e ? "R3" : "R4");
                issue(1'b0, a + 1, 8'h00, e[0], w[1:0], 1'b1, 2, -1, "R7");
                issue(1'b0, a + 2, 8'h00, e[0], w[1:0], 1'b1, 5, -1, "R7");
                issue(1'b0, a + 3, 8'h00, e[0], w[1:0], 1'b0, 5, -1, "R7");
            end
        end

        // R5: outside the wait region
        issue(1'b0, 18'h00456, 8'h00, 1'b1, 2'b00, 1'b0, 0, -1, "R5");
        issue(1'b1, 18'h2A0F3, 8'hC3, 1'b0, 2'b00, 1'b0, 0, -1, "R5");

        // R9: writes in the wait region
        issue(1'b1, 18'h1ABCD, 8'h96, 1'b1, 2'b01, 1'b0, 0, -1, "R9");
        issue(1'b1, 18'h10011, 8'h3C, 1'b0, 2'b10, 1'b1, 4, -1, "R9");

        // R6: back-to-back gap, compatible then extended float
        issue(1'b0, 18'h10100, 8'h00, 1'b1, 2'b11, 1'b0, 0, -1, "R6");
        issue(1'b0, 18'h10101, 8'h00, 1'b1, 2'b11, 1'b0, 0, 1, "R6");
        issue(1'b0, 18'h10102, 8'h00, 1'b0, 2'b11, 1'b0, 0, -1, "R6");
        issue(1'b0, 18'h10103, 8'h00, 1'b0, 2'b11, 1'b0, 0, 2, "R6");

        // R12: configuration changed during the cycle
        issue(1'b0, 18'h10200, 8'h00, 1'b1, 2'b00, 1'b0, 0, -1, "R12");
        cfg_wsb = 2'b11;
        cfg_edf = 1'b0;
        while (q.size() != 0) @(negedge clk);

        // R11: wait clock
        wclk_en = 1'b1;
        prev = wclk;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(wclk != prev, "R11", "wclk toggle", int'(wclk), int'(~prev));
            prev = wclk;
        end
        wclk_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(wclk == 1'b0, "R11", "wclk idle low", int'(wclk), 0);
            @(negedge clk);
        end

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule